// File: doc/BRIEF.md
# Depth-Cascade Token Controller

This block sits beside one FIFO slice in a chain of slices that are cascaded to make a deeper queue. Two tokens travel separately along the chain: one allows writing and one allows reading. A slice accepts write strobes only while it holds the write token. When it writes the final location of its memory, it hands the token on by sending a one-cycle pulse on its write hand-off output. Reads work the same way with the read token and the read hand-off output. Each slice's hand-off inputs are wired to the hand-off outputs of the slice before it. The slice marked as the head of the chain starts out holding both tokens.

A static strap selects standalone operation. In that mode the slice keeps both tokens for good and the read hand-off output stays low. The write hand-off output becomes an active-low half-full indicator, computed from the difference between the slice's write and read pointers. Both pointers come from the slice, carry one extra wrap bit, and show the state before the current strobe. The block uses one clock for both sides.

Top module: `xpn_depth_ctrl`

## Requirements
- R1: After synchronous reset, a slice in chain mode holds both tokens if `first_load_n` is low and neither token if it is high. `wx_out` and `rx_out` are low in chain mode, and `wx_out` is high in standalone mode.
- R2: In chain mode, `wr_accept` equals `wr_req` while the write token is held and is 0 otherwise. Once the token has been handed off, no write is accepted unless it is regained.
- R3: In chain mode, `rd_accept` equals `rd_req` while the read token is held and is 0 otherwise.
- R4: In chain mode, an accepted write with `wr_ptr[AW-1:0] == DEPTH-1` (where AW = log2 DEPTH) drives `wx_out` high for exactly the following cycle and releases the write token.
- R5: In chain mode, an accepted read with `rd_ptr[AW-1:0] == DEPTH-1` drives `rx_out` high for exactly the following cycle and releases the read token.
- R6: A chain-mode slice without the write token takes it when `wx_in` is high at a clock edge, and accepts writes from the next cycle.
- R7: A chain-mode slice without the read token takes it when `rx_in` is high at a clock edge, and accepts reads from the next cycle.
- R8: In standalone mode (`chain_en` low), every strobe is accepted, writing or reading the last location releases nothing, and `rx_out` stays low.
- R9: In standalone mode, `wx_out` goes low in the cycle after an accepted write that raises the occupancy (`wr_ptr - rd_ptr`) above DEPTH/2. At exactly DEPTH/2 it stays high.
- R10: In standalone mode, `wx_out` returns high in the cycle after an accepted read that leaves the occupancy at DEPTH/2 or less.
- R11: In standalone mode, an accepted write and an accepted read in the same cycle leave `wx_out` unchanged.
- R12: A pulse on `wx_in` while the write token is already held has no effect. The token is still released by the next last-location write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write and read sides |
| rst | input | 1 | Synchronous active-high reset |
| chain_en | input | 1 | Strap: 1 = chain mode, 0 = standalone half-full mode |
| first_load_n | input | 1 | Low on the head slice of the chain |
| wx_in | input | 1 | Write-token pulse from the previous slice |
| rx_in | input | 1 | Read-token pulse from the previous slice |
| wr_req | input | 1 | Write strobe from the producer |
| rd_req | input | 1 | Read strobe from the consumer |
| wr_ptr | input | AW+1 | Slice write pointer with wrap bit, value before this strobe |
| rd_ptr | input | AW+1 | Slice read pointer with wrap bit, value before this strobe |
| wr_accept | output | 1 | Write strobe passed on to the slice memory |
| rd_accept | output | 1 | Read strobe passed on to the slice memory |
| wx_out | output | 1 | Write-token pulse (chain) or active-low half-full flag (standalone) |
| rx_out | output | 1 | Read-token pulse to the next slice |

## Verification
The assertions rely on four things about the inputs. The pointers advance only on accepted strobes. `chain_en` changes only while reset is held. The slice never reads while empty or writes while full. Token pulses last one cycle. The stimulus follows all of these: it changes the strap only inside a reset sequence, and in standalone runs it derives the pointer values from the accepts it has seen. In chain runs the pointer values are given in each step and only matter through their low bits.

// File: rtl/xpn_pkg.sv
package xpn_pkg;

    typedef enum logic {
        XPN_STANDALONE = 1'b0,
        XPN_CHAIN      = 1'b1
    } xpn_mode_e;

    // Index of each side in the two-entry side vectors
    localparam int XPN_WR = 0;
    localparam int XPN_RD = 1;

    typedef struct packed {
        logic rd;
        logic wr;
    } xpn_pair_t;

    // True when the pointer addresses the final slot of a power-of-two memory
    function automatic logic at_last_slot(input int unsigned ptr, input int unsigned depth);
        return (ptr & (depth - 1)) == (depth - 1);
    endfunction

endpackage

// File: rtl/xpn_token.sv
module xpn_token
    import xpn_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  xpn_mode_e mode,
    input  logic      first_n,
    input  logic      tok_in,
    input  logic      req,
    input  logic      at_last,
    output logic      accept,
    output logic      tok_out
);

    logic own_q;
    logic own_eff;
    logic release_now;

    assign own_eff     = own_q | (mode == XPN_STANDALONE);
    assign accept      = req & own_eff;
    assign release_now = (mode == XPN_CHAIN) & own_q & req & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q   <= ~first_n;
            tok_out <= 1'b0;
        end else begin
            tok_out <= release_now;
            if (mode == XPN_CHAIN) begin
                if (release_now) begin
                    own_q <= 1'b0;
                end else if (tok_in && !own_q) begin
                    own_q <= 1'b1;
                end
            end
        end
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        tok_out |=> !tok_out);  // R4
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tok_out |-> $past(accept && at_last));  // R5
    AST_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (tok_out && !tok_in) |=> !accept);  // R2
    AST_STANDALONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == XPN_STANDALONE) |-> !tok_out);  // R8

endmodule

// File: rtl/xpn_half_full.sv
module xpn_half_full #(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          wr_acc,
    input  logic          rd_acc,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    output logic          hf_n
);

    localparam logic [PW:0] HALF_V = (PW + 1)'(DEPTH / 2);

    logic [PW-1:0] diff;
    logic [PW:0]   occ;
    logic [PW:0]   nxt;

    assign diff = wr_ptr - rd_ptr;
    assign occ  = {1'b0, diff};
    assign nxt  = occ + {{PW{1'b0}}, wr_acc} - {{PW{1'b0}}, rd_acc};

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            hf_n <= 1'b1;
        end else if (wr_acc && !rd_acc && nxt > HALF_V) begin
            hf_n <= 1'b0;
        end else if (rd_acc && !wr_acc && nxt <= HALF_V) begin
            hf_n <= 1'b1;
        end
    end

    AST_HF_SET: assert property (@(posedge clk) disable iff (rst)
        (active && wr_acc && !rd_acc && occ >= HALF_V) |=> !hf_n);  // R9
    AST_HF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (active && rd_acc && !wr_acc && occ != '0 && occ <= HALF_V + 1'b1) |=> hf_n);  // R10
    AST_HF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && wr_acc && rd_acc) |=> $stable(hf_n));  // R11

endmodule

// File: rtl/xpn_depth_ctrl.sv
module xpn_depth_ctrl
    import xpn_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chain_en,
    input  logic          first_load_n,
    input  logic          wx_in,
    input  logic          rx_in,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    output logic          wr_accept,
    output logic          rd_accept,
    output logic          wx_out,
    output logic          rx_out
);

    xpn_mode_e mode;
    xpn_pair_t req_v, tin_v, last_v, acc_v, tout_v;
    logic      hf_n;

    assign mode      = chain_en ? XPN_CHAIN : XPN_STANDALONE;
    assign req_v     = '{rd: rd_req, wr: wr_req};
    assign tin_v     = '{rd: rx_in, wr: wx_in};
    assign last_v.wr = at_last_slot(32'(wr_ptr), DEPTH);
    assign last_v.rd = at_last_slot(32'(rd_ptr), DEPTH);

    for (genvar g = 0; g < 2; g++) begin : g_side
        xpn_token u_tok (
            .clk     (clk),
            .rst     (rst),
            .mode    (mode),
            .first_n (first_load_n),
            .tok_in  (tin_v[g]),
            .req     (req_v[g]),
            .at_last (last_v[g]),
            .accept  (acc_v[g]),
            .tok_out (tout_v[g])
        );
    end

    xpn_half_full #(.DEPTH(DEPTH)) u_hf (
        .clk    (clk),
        .rst    (rst),
        .active (mode == XPN_STANDALONE),
        .wr_acc (acc_v.wr),
        .rd_acc (acc_v.rd),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .hf_n   (hf_n)
    );

    assign wr_accept = acc_v.wr;
    assign rd_accept = acc_v.rd;
    assign wx_out    = (mode == XPN_CHAIN) ? tout_v.wr : hf_n;
    assign rx_out    = tout_v.rd;

    AST_RX_IDLE_SOLO: assert property (@(posedge clk) disable iff (rst)
        !chain_en |-> !rx_out);  // R8
    AST_SOLO_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!chain_en && wr_req) |-> wr_accept);  // R8

endmodule

// File: tb/tb_xpn_depth_ctrl.sv
`timescale 1ns/1ps
module tb_xpn_depth_ctrl;

    localparam int DEPTH = 16;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chain_en = 1'b1, first_load_n = 1'b0, wx_in = 1'b0, rx_in = 1'b0;
    logic wr_req = 1'b0, rd_req = 1'b0;
    logic [PW-1:0] wr_ptr = '0, rd_ptr = '0;
    logic wr_accept, rd_accept, wx_out, rx_out;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;  // 125 MHz

    xpn_depth_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .chain_en(chain_en), .first_load_n(first_load_n),
        .wx_in(wx_in), .rx_in(rx_in), .wr_req(wr_req), .rd_req(rd_req),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_accept(wr_accept), .rd_accept(rd_accept),
        .wx_out(wx_out), .rx_out(rx_out)
    );

    // Step vector: {wx, rx, wr, rd, wptr[4:0], rptr[4:0], exp_wacc, exp_racc, exp_wxo, exp_rxo}
    localparam int NSTEP = 12;
    localparam logic [17:0] STEPS [NSTEP] = '{
        18'b0011_00000_00000_0000, // no token yet: R2 R3
        18'b1000_00000_00000_0000, // write token arrives: R6
        18'b1010_00101_00000_1000, // extra pulse while owning: R12
        18'b0010_01111_00000_1010, // last write slot: R4
        18'b0010_10000_00000_0000, // token gone, pulse ended: R2 R4
        18'b0100_00000_00000_0000, // read token arrives: R7
        18'b0001_00000_00011_0100, // read accepted: R7
        18'b0001_00000_11111_0101, // last read slot: R5
        18'b0001_00000_00000_0000, // read token gone: R3 R5
        18'b1010_01111_00000_0000, // pulse this cycle, not owned yet: R6
        18'b0010_01111_00000_1010, // regained and released again: R12
        18'b1010_00001_00000_0000  // not owned: R2
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic chain, input logic first_n);
        @(negedge clk);
        rst = 1'b1; chain_en = chain; first_load_n = first_n;
        wx_in = 1'b0; rx_in = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
        wr_ptr = '0; rd_ptr = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    logic [PW-1:0] wp, rp;

    // One standalone step; the bench pointer model advances on observed accepts
    task automatic solo_step(input logic w, input logic r, input string tag);
        logic wa, ra;
        @(negedge clk);
        wr_req = w; rd_req = r; wr_ptr = wp; rd_ptr = rp;
        #1;
        wa = wr_accept; ra = rd_accept;
        check({tag, " accept-wr"}, wa, w);
        check({tag, " accept-rd"}, ra, r);
        @(posedge clk); #1;
        if (wa) wp = wp + 1'b1;
        if (ra) rp = rp + 1'b1;
        wr_req = 1'b0; rd_req = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: head slice in chain mode owns both tokens
        do_reset(1'b1, 1'b0);
        wr_req = 1'b1; rd_req = 1'b1; #1;
        check("R1 head wr token", wr_accept, 1'b1);
        check("R1 head rd token", rd_accept, 1'b1);
        check("R1 wx_out idle", wx_out, 1'b0);
        check("R1 rx_out idle", rx_out, 1'b0);

        // Table walk: non-head slice in chain mode
        do_reset(1'b1, 1'b1);
        #1;
        check("R1 non-head wx_out", wx_out, 1'b0);
        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            {wx_in, rx_in, wr_req, rd_req} = STEPS[i][17:14];
            wr_ptr = STEPS[i][13:9];
            rd_ptr = STEPS[i][8:4];
            #1;
            check("R2 wr accept", wr_accept, STEPS[i][3]);
            check("R3 rd accept", rd_accept, STEPS[i][2]);
            @(posedge clk); #1;
            check("R4 wx pulse", wx_out, STEPS[i][1]);
            check("R5 rx pulse", rx_out, STEPS[i][0]);
        end
        @(negedge clk);
        wx_in = 1'b0; rx_in = 1'b0; wr_req = 1'b0; rd_req = 1'b0;

        // Standalone half-full mode
        do_reset(1'b0, 1'b0);
        wp = '0; rp = '0;
        #1;
        check("R1 standalone wx_out high", wx_out, 1'b1);
        for (int i = 0; i < DEPTH / 2; i++) solo_step(1'b1, 1'b0, "R8");
        check("R9 exactly half stays high", wx_out, 1'b1);
        solo_step(1'b1, 1'b0, "R9");
        check("R9 above half goes low", wx_out, 1'b0);
        solo_step(1'b1, 1'b1, "R11");
        check("R11 simultaneous keeps low", wx_out, 1'b0);
        solo_step(1'b0, 1'b1, "R10");
        check("R10 back to half goes high", wx_out, 1'b1);
        solo_step(1'b1, 1'b1, "R11");
        check("R11 simultaneous keeps high", wx_out, 1'b1);
        // Fill to full, crossing the last write slot
        for (int i = 0; i < DEPTH / 2; i++) begin
            solo_step(1'b1, 1'b0, "R8");
            check("R8 rx_out quiet", rx_out, 1'b0);
        end
        check("R9 full is low", wx_out, 1'b0);
        for (int i = 0; i < DEPTH / 2 - 1; i++) solo_step(1'b0, 1'b1, "R8");
        check("R10 still above half", wx_out, 1'b0);
        solo_step(1'b0, 1'b1, "R10");
        check("R10 half after reads", wx_out, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule